// File: doc/BRIEF.md
# MIDI Host Port Interface

This block is the host-facing side of a legacy MIDI port. It exposes two byte addresses. Address 0 is the data port: a host read takes the oldest byte from a 16-entry receive queue, and a host write hands a byte to a single transmit holding stage that offers it downstream over a valid/ready handshake. Address 1 reads as a status byte and writes as a command byte. The receive queue is fed by two sources: bytes from the serial receiver, and acknowledge bytes (0xFE) that a small command decoder injects after a reset (0xFF) or pass-through (0x3F) command. Both kinds of byte leave through the same data port.

A single active-high interrupt signals that the receive queue holds at least one byte. It is gated by an `activate` configuration input. Transmit traffic never touches it. Receive bytes that arrive while the queue is full are dropped, and a sticky debug flag records the loss.

Two small state machines do the control work. The command decoder has states CMD_IDLE and CMD_ACK. In CMD_IDLE, a write of 0xFF or 0x3F to address 1 moves it to CMD_ACK. In CMD_ACK, it pushes 0xFE as soon as no receive byte competes for the queue and the queue has room, then returns to CMD_IDLE. The transmit holder has states TX_IDLE and TX_BUSY. In TX_IDLE, a data write latches the byte and moves it to TX_BUSY. In TX_BUSY, acceptance by the downstream handshake returns it to TX_IDLE.

Top module: `midi_host_port`

## Requirements
- R1: Status bit 7 (read at address 1) is 1 when the receive queue is empty and 0 when it holds a byte.
- R2: Status bit 6 is 1 while a data byte waits for downstream acceptance and 0 otherwise.
- R3: Status bits 5:0 always read 0, also after any write to address 1.
- R4: A write to address 1 is a command and never reaches the transmit output. A read of address 1 never removes a queued byte.
- R5: `irq` is 1 exactly when `activate` is 1 and the receive queue is not empty. It is 0 whenever `activate` is 0.
- R6: A data-port read returns the oldest queued byte and removes it. While bytes remain after the read, `irq` stays 1 on every cycle with no gap.
- R7: A command of 0xFF or 0x3F leaves the queue unchanged at the clock edge that takes the write, and adds 0xFE at the next edge. 0xFE is read back through the data port in arrival order with the MIDI bytes. Every other command code changes nothing.
- R8: A data write in TX_IDLE drives `tx_valid` high with that byte on `tx_byte`, holding both stable until `tx_ready` is seen. A data write in TX_BUSY is discarded.
- R9: A receive byte presented while the queue holds 16 bytes is dropped, and `rx_overflow` goes to 1 and stays 1 until reset.
- R10: Transmit writes, transmit busy and transmit handshakes do not change `irq`.
- R11: Synchronous reset empties the queue, returns both state machines to idle, clears `rx_overflow`, and drives `irq` and `tx_valid` to 0.
- R12: A data-port read with the queue empty returns 0x00 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 1 | 0 selects the data port, 1 the status/command port |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte, combinational from the current address and state |
| activate | input | 1 | Interrupt enable from configuration |
| irq | output | 1 | Receive-data interrupt, active high |
| rx_valid | input | 1 | Serial receiver presents a byte this cycle |
| rx_byte | input | 8 | Received MIDI byte |
| tx_valid | output | 1 | A transmit byte is offered downstream |
| tx_ready | input | 1 | Downstream accepts the offered byte |
| tx_byte | output | 8 | Transmit byte |
| rx_overflow | output | 1 | Sticky flag: a receive byte was dropped (debug) |

## Verification
The data port is exercised with single MIDI bytes, with bursts of four that are drained while `irq` is watched after every pop, and with MIDI bytes interleaved with both acknowledging commands and a non-acknowledging one. This separates queue ordering, acknowledge injection and timing, and the filtering of command codes. A run that fills the queue to 16 entries and then offers one more byte separates the full boundary from the overflow drop. A transmit sequence with a write during TX_BUSY, held once with the queue empty and once with it occupied, shows that discarded writes and transmit handshakes leave the interrupt alone.

// File: rtl/midi_port_pkg.sv
package midi_port_pkg;

    typedef enum logic [0:0] {
        CMD_IDLE = 1'b0,
        CMD_ACK  = 1'b1
    } cmd_state_t;

    typedef enum logic [0:0] {
        TX_IDLE = 1'b0,
        TX_BUSY = 1'b1
    } tx_state_t;

    localparam logic [7:0] CMD_CODE_RESET    = 8'hFF;
    localparam logic [7:0] CMD_CODE_PASSTHRU = 8'h3F;
    localparam logic [7:0] ACK_BYTE          = 8'hFE;

endpackage

// File: rtl/midi_rx_fifo.sv
module midi_rx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  logic [WIDTH-1:0]         push_data,
    input  logic                     pop,
    output logic [WIDTH-1:0]         head,
    output logic                     empty,
    output logic                     full,
    output logic [$clog2(DEPTH):0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/midi_cmd_ctrl.sv
module midi_cmd_ctrl
    import midi_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_code,
    input  logic       blocked,
    output logic       ack_push
);
    cmd_state_t state_q;
    cmd_state_t state_d;
    logic       wants_ack;

    assign wants_ack = (cmd_code == CMD_CODE_RESET) || (cmd_code == CMD_CODE_PASSTHRU);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CMD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        ack_push = 1'b0;
        unique case (state_q)
            CMD_IDLE: begin
                if (cmd_wr && wants_ack) begin
                    state_d = CMD_ACK;
                end
            end
            CMD_ACK: begin
                if (!blocked) begin
                    ack_push = 1'b1;
                    state_d  = CMD_IDLE;
                end
            end
            default: state_d = CMD_IDLE;
        endcase
    end
endmodule

// File: rtl/midi_tx_hold.sv
module midi_tx_hold
    import midi_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_data,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_byte
);
    tx_state_t state_q;
    tx_state_t state_d;
    logic      capture;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
            tx_byte <= '0;
        end else begin
            state_q <= state_d;
            if (capture) begin
                tx_byte <= load_data;
            end
        end
    end

    always_comb begin
        state_d  = state_q;
        capture  = 1'b0;
        tx_valid = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                if (load) begin
                    capture = 1'b1;
                    state_d = TX_BUSY;
                end
            end
            TX_BUSY: begin
                tx_valid = 1'b1;
                if (tx_ready) begin
                    state_d = TX_IDLE;
                end
            end
            default: state_d = TX_IDLE;
        endcase
    end
endmodule

// File: rtl/midi_host_port.sv
module midi_host_port
    import midi_port_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_addr,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       activate,
    output logic       irq,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output logic       tx_valid,
    input  logic       tx_ready,
    output logic [7:0] tx_byte,
    output logic       rx_overflow
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic          data_wr;
    logic          cmd_wr;
    logic          data_rd;
    logic          ack_push;
    logic          fifo_push;
    logic [7:0]    fifo_in;
    logic [7:0]    fifo_head;
    logic          fifo_empty;
    logic          fifo_full;
    logic [CW-1:0] fifo_count;

    assign data_wr = host_wr && !host_addr;
    assign cmd_wr  = host_wr &&  host_addr;
    assign data_rd = host_rd && !host_addr;

    // receiver bytes win the single queue write port; an acknowledge waits
    assign fifo_push = rx_valid || ack_push;
    assign fifo_in   = rx_valid ? rx_byte : ACK_BYTE;

    midi_rx_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (fifo_push),
        .push_data (fifo_in),
        .pop       (data_rd),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .count     (fifo_count)
    );

    midi_cmd_ctrl u_cmd (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (cmd_wr),
        .cmd_code (host_wdata),
        .blocked  (rx_valid || fifo_full),
        .ack_push (ack_push)
    );

    midi_tx_hold u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (data_wr),
        .load_data (host_wdata),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_overflow <= 1'b0;
        end else if (rx_valid && fifo_full) begin
            rx_overflow <= 1'b1;
        end
    end

    always_comb begin
        if (host_addr) begin
            host_rdata = {fifo_empty, tx_valid, 6'b000000};
        end else begin
            host_rdata = fifo_empty ? 8'h00 : fifo_head;
        end
    end

    assign irq = activate && !fifo_empty;
endmodule

// File: rtl/midi_host_port_chk.sv
module midi_host_port_chk #(
    parameter int DEPTH = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   host_addr,
    input logic [7:0]             host_rdata,
    input logic                   activate,
    input logic                   irq,
    input logic                   rx_valid,
    input logic                   tx_valid,
    input logic                   tx_ready,
    input logic [7:0]             tx_byte,
    input logic                   rx_overflow,
    input logic [$clog2(DEPTH):0] fifo_count
);
    localparam int CW = $clog2(DEPTH) + 1;

    assert_status_empty_R1: assert property (@(posedge clk) disable iff (rst)
        host_addr |-> (host_rdata[7] == (fifo_count == '0)));

    assert_status_busy_R2: assert property (@(posedge clk) disable iff (rst)
        host_addr |-> (host_rdata[6] == tx_valid));

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
        host_addr |-> (host_rdata[5:0] == 6'd0));

    assert_irq_gated_R5: assert property (@(posedge clk) disable iff (rst)
        !activate |-> !irq);

    assert_irq_no_gap_R6: assert property (@(posedge clk) disable iff (rst)
        (activate && $past(activate) && ($past(fifo_count) > CW'(1))) |-> irq);

    assert_tx_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CW'(DEPTH));

    assert_overflow_set_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && (fifo_count == CW'(DEPTH))) |=> rx_overflow);

    assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        rx_overflow |=> rx_overflow);

    assert_reset_state_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && !tx_valid && !rx_overflow && (fifo_count == '0)));
endmodule

bind midi_host_port midi_host_port_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_addr   (host_addr),
    .host_rdata  (host_rdata),
    .activate    (activate),
    .irq         (irq),
    .rx_valid    (rx_valid),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_byte     (tx_byte),
    .rx_overflow (rx_overflow),
    .fifo_count  (fifo_count)
);

// File: tb/sim_midi_host_port.sv
module sim_midi_host_port;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_addr = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       activate = 1'b0;
    logic       irq;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_valid;
    logic       tx_ready = 1'b0;
    logic [7:0] tx_byte;
    logic       rx_overflow;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_rx[$];
    logic [7:0] exp_tx[$];
    bit   tb_busy = 1'b0;

    always #2 clk = ~clk;

    midi_host_port #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .activate(activate), .irq(irq), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
        .rx_overflow(rx_overflow)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the transmit scoreboard on every downstream handshake
    always @(posedge clk) begin
        if (!rst && tx_valid && tx_ready) begin
            if (exp_tx.size() == 0) begin
                check(1'b0, "R8 unexpected tx byte", tx_byte, 0);
            end else begin
                automatic logic [7:0] e = exp_tx.pop_front();
                check(tx_byte == e, "R8 tx byte", tx_byte, e);
            end
            tb_busy = 1'b0;
        end
    end

    task automatic midi_in(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        if (exp_rx.size() < DEPTH) exp_rx.push_back(b);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic host_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        host_addr  = a;
        host_wr    = 1'b1;
        host_wdata = d;
        if (!a && !tb_busy) begin
            exp_tx.push_back(d);
            tb_busy = 1'b1;
        end
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic read_data(input string tag);
        logic [7:0] e;
        @(negedge clk);
        host_addr = 1'b0;
        host_rd   = 1'b1;
        #1;
        e = (exp_rx.size() > 0) ? exp_rx.pop_front() : 8'h00;
        check(host_rdata == e, tag, host_rdata, e);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic read_status(input logic [7:0] e, input string tag);
        @(negedge clk);
        host_addr = 1'b1;
        host_rd   = 1'b1;
        #1;
        check(host_rdata == e, tag, host_rdata, e);
        @(negedge clk);
        host_rd   = 1'b0;
        host_addr = 1'b0;
    endtask

    task automatic expect_irq(input string tag);
        logic e;
        e = activate && (exp_rx.size() > 0);
        check(irq == e, tag, irq, e);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        check(irq == 1'b0, "R11 irq after reset", irq, 0);
        check(tx_valid == 1'b0, "R11 tx_valid after reset", tx_valid, 0);
        read_status(8'h80, "R1 R2 status after reset");

        activate = 1'b1;
        read_data("R12 empty read returns 0x00");
        read_status(8'h80, "R12 empty read left state alone");

        // single byte, irq and gating
        midi_in(8'h90);
        expect_irq("R5 irq with one byte");
        read_status(8'h00, "R1 status with byte queued");
        @(negedge clk); activate = 1'b0; #1;
        check(irq == 1'b0, "R5 irq gated by activate", irq, 0);
        @(negedge clk); activate = 1'b1; #1;
        expect_irq("R5 irq restored by activate");

        // burst and no-gap drain
        midi_in(8'h3C); midi_in(8'h7F); midi_in(8'h01);
        for (int i = 0; i < 4; i++) begin
            read_data("R6 fifo order");
            expect_irq("R6 irq after pop");
        end

        // command acknowledge timing
        host_write(1'b1, 8'hFF);
        check(irq == 1'b0, "R7 no ack at command edge", irq, 0);
        exp_rx.push_back(8'hFE);
        @(negedge clk);
        expect_irq("R7 ack one cycle later");
        read_data("R7 ack byte for 0xFF");

        // interleaved: byte, passthru command, byte, ignored command
        midi_in(8'hB0);
        host_write(1'b1, 8'h3F);
        exp_rx.push_back(8'hFE);
        @(negedge clk);
        midi_in(8'h40);
        host_write(1'b1, 8'h12);
        repeat (3) @(negedge clk);
        check(tx_valid == 1'b0, "R4 command not transmitted", tx_valid, 0);
        read_status(8'h00, "R4 status read does not pop");
        read_data("R7 interleave byte 1");
        read_data("R7 interleave ack");
        read_data("R7 interleave byte 2");
        read_status(8'h80, "R7 ignored command added nothing");
        read_data("R7 queue empty after ignored command");

        // reserved bits after writes to offset 1
        host_write(1'b1, 8'h00);
        read_status(8'h80, "R3 reserved bits zero");

        // transmit path with empty queue
        tx_ready = 1'b0;
        host_write(1'b0, 8'h45);
        check(tx_valid == 1'b1, "R8 tx_valid after data write", tx_valid, 1);
        check(tx_byte == 8'h45, "R8 tx_byte after data write", tx_byte, 8'h45);
        expect_irq("R10 irq low while busy");
        read_status(8'hC0, "R2 busy status");
        host_write(1'b0, 8'h77);
        check(tx_byte == 8'h45, "R8 write while busy discarded", tx_byte, 8'h45);
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
        check(tx_valid == 1'b0, "R8 busy cleared by handshake", tx_valid, 0);
        check(exp_tx.size() == 0, "R8 tx scoreboard drained", exp_tx.size(), 0);
        read_status(8'h80, "R2 idle status");

        // transmit path with occupied queue
        midi_in(8'h99);
        host_write(1'b0, 8'h5A);
        expect_irq("R10 irq kept during tx write");
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0; #1;
        expect_irq("R10 irq kept after tx handshake");
        read_data("R10 queued byte intact");

        // fill to the boundary, then overflow
        for (int i = 0; i < DEPTH; i++) midi_in(8'(8'h20 + i));
        check(rx_overflow == 1'b0, "R9 no overflow at exactly full", rx_overflow, 0);
        midi_in(8'hAA);
        check(rx_overflow == 1'b1, "R9 overflow flag set", rx_overflow, 1);
        for (int i = 0; i < DEPTH; i++) read_data("R9 kept bytes, dropped one absent");
        read_data("R9 queue empty after drain");
        check(rx_overflow == 1'b1, "R9 overflow flag sticky", rx_overflow, 1);

        // reset mid-activity
        midi_in(8'h11);
        host_write(1'b0, 8'h22);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        exp_rx.delete(); exp_tx.delete(); tb_busy = 1'b0;
        #1;
        check(irq == 1'b0, "R11 irq after mid reset", irq, 0);
        check(tx_valid == 1'b0, "R11 tx idle after mid reset", tx_valid, 0);
        check(rx_overflow == 1'b0, "R11 overflow cleared", rx_overflow, 0);
        read_status(8'h80, "R11 status after mid reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule